// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is the serial front end of a small general-purpose I/O expander. It runs on a fast system clock, oversamples the I2C clock and data lines through synchronisers, recognises START and STOP conditions, and answers a 7-bit address. The upper four address bits are a fixed prefix (0100 by default). The lower three bits are taken from strap inputs, so several expanders can share one bus.

After a write address, the first byte the master sends is a command byte. Its low two bits set a register pointer. Every later data byte in that write is handed to the GPIO core as a write strobe aimed at the pointed register. Read transactions stream the pointed register's contents, MSB first, for as long as the master acknowledges. The pointer keeps its value across transactions until the next command byte replaces it, so the usual pattern of write-command, repeated START, read works, and so do later bare reads. The block only pulls SDA low through an output enable. It never stretches SCL.

Top module: `i2c_regptr_target`

## Requirements
- R1: After reset the target leaves SDA released (`sda_oe` = 0), raises no strobe, and the register index is 0.
- R2: SDA falling while SCL is high is a START. A START at any point, including in the middle of a byte, discards the transfer in progress and begins a new address phase. SDA rising while SCL is high is a STOP, and a STOP returns the target to idle.
- R3: An address byte equal to 0100 followed by `strap[2]`, `strap[1]`, `strap[0]` in bits 7..1, MSB first, is acknowledged. The target drives SDA low during the ninth clock. Bit 0 chooses the direction: 1 is read, 0 is write.
- R4: Any other address byte gets no acknowledge and no strobe. The target ignores every byte after it until the next START.
- R5: The first byte after a write address is acknowledged and loads the pointer with its bits 1..0. `reg_idx` shows the pointer.
- R6: Each later byte in the same write is acknowledged. Each one produces exactly one `wr_stb` pulse, with `wr_data` equal to the byte and `reg_idx` unchanged, so consecutive bytes all land in the same register.
- R7: The pointer keeps its value across STOP and repeated START. A read with no new command byte returns the register chosen last.
- R8: In a read, each byte gives one `rd_stb` pulse and shifts out `rd_data`, MSB first. A master acknowledge causes one more byte from the same register.
- R9: After a master NACK the target keeps SDA released until the next START or STOP.
- R10: `sda_oe` changes only while SCL is low.
- R11: `wr_stb` and `rd_stb` are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap | input | 3 | Pin-strapped low address bits |
| reg_idx | output | 2 | Current register pointer |
| wr_stb | output | 1 | One-cycle write strobe to the GPIO core |
| wr_data | output | 8 | Byte being written |
| rd_stb | output | 1 | One-cycle pulse when a byte is taken for transmission |
| rd_data | input | 8 | Contents of the register at `reg_idx` |

## Verification
A wrong byte phase or bit count shows up on the very next ninth clock: the acknowledge is missing or lands where it should not, or a strobe fires off its byte boundary. A corrupted pointer stays hidden until a strobe fires or a bare read returns the wrong register. For that reason the bench compares `reg_idx` against its model on every idle clock and reads back through the bus after each pointer change. A stuck transmit state shows as SDA held low after a NACK, which the bench checks before it issues the STOP.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_WAIT
  } tgt_st_e;

  typedef enum logic [1:0] {
    BK_ADDR, BK_CMD, BK_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '1;
      prev_q <= 1'b1;
    end else begin
      chain  <= {chain[STAGES-2:0], d};
      prev_q <= chain[STAGES-1];
    end
  end

  assign q      = chain[STAGES-1];
  assign q_prev = prev_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic scl,
  input  logic scl_p,
  input  logic sda,
  input  logic sda_p,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  always_comb begin
    scl_rise = scl & ~scl_p;
    scl_fall = ~scl & scl_p;
    start_c  = scl & scl_p & sda_p & ~sda;
    stop_c   = scl & scl_p & ~sda_p & sda;
  end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 2,
  parameter int AW = 3,
  parameter logic [6-AW:0] PREFIX = 4'b0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_c,
  input  logic          stop_c,
  input  logic [AW-1:0] strap,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe,
  output logic [PW-1:0] ptr,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data,
  output logic          rd_stb
);
  localparam int PFX_W = 7 - AW;
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW);

  tgt_st_e          st, st_n;
  byte_kind_e       kind, kind_n;
  logic             rw, rw_n;
  logic [CNT_W-1:0] bits, bits_n;
  logic [DW-1:0]    sh, sh_n;
  logic             oe, oe_n;
  logic [PW-1:0]    ptr_q, ptr_n;
  logic             wr_q, wr_n, rd_q, rd_n;
  logic             mok, mok_n;

  always_comb begin
    st_n = st; kind_n = kind; rw_n = rw; bits_n = bits; sh_n = sh;
    oe_n = oe; ptr_n = ptr_q; wr_n = 1'b0; rd_n = 1'b0; mok_n = mok;
    if (stop_c) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (start_c) begin
      st_n   = ST_RX;
      kind_n = BK_ADDR;
      bits_n = '0;
      oe_n   = 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise) begin
            sh_n   = {sh[DW-2:0], sda};
            bits_n = bits + CNT_W'(1);
          end else if (scl_fall && bits == LAST) begin
            bits_n = '0;
            case (kind)
              BK_ADDR: begin
                if (sh[DW-1 -: PFX_W] == PREFIX && sh[AW:1] == strap) begin
                  oe_n = 1'b1; st_n = ST_ACK; rw_n = sh[0]; kind_n = BK_CMD;
                end else begin
                  st_n = ST_IDLE;
                end
              end
              BK_CMD: begin
                ptr_n = sh[PW-1:0]; oe_n = 1'b1; st_n = ST_ACK; kind_n = BK_DATA;
              end
              default: begin
                wr_n = 1'b1; oe_n = 1'b1; st_n = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (rw) begin
              rd_n = 1'b1; sh_n = rd_data; oe_n = ~rd_data[DW-1];
              st_n = ST_TX; bits_n = '0;
            end else begin
              oe_n = 1'b0; st_n = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bits_n = bits + CNT_W'(1);
          end else if (scl_fall) begin
            if (bits == LAST) begin
              oe_n = 1'b0; st_n = ST_MACK; bits_n = '0;
            end else begin
              sh_n = {sh[DW-2:0], 1'b0}; oe_n = ~sh[DW-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mok_n = ~sda;
          end else if (scl_fall) begin
            if (mok) begin
              rd_n = 1'b1; sh_n = rd_data; oe_n = ~rd_data[DW-1];
              st_n = ST_TX; bits_n = '0;
            end else begin
              st_n = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; kind <= BK_ADDR; rw <= 1'b0; bits <= '0; sh <= '0;
      oe <= 1'b0; ptr_q <= '0; wr_q <= 1'b0; rd_q <= 1'b0; mok <= 1'b0;
    end else begin
      st <= st_n; kind <= kind_n; rw <= rw_n; bits <= bits_n; sh <= sh_n;
      oe <= oe_n; ptr_q <= ptr_n; wr_q <= wr_n; rd_q <= rd_n; mok <= mok_n;
    end
  end

  assign sda_oe  = oe;
  assign ptr     = ptr_q;
  assign wr_stb  = wr_q;
  assign wr_data = sh;
  assign rd_stb  = rd_q;
endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target #(
  parameter int DATA_W = 8,
  parameter int PTR_W = 2,
  parameter int STRAP_W = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [6-STRAP_W:0] PREFIX = 4'b0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  output logic [PTR_W-1:0]   reg_idx,
  output logic               wr_stb,
  output logic [DATA_W-1:0]  wr_data,
  output logic               rd_stb,
  input  logic [DATA_W-1:0]  rd_data
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw, syn, prv;
  logic scl_rise, scl_fall, start_c, stop_c;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw[g]), .q(syn[g]), .q_prev(prv[g])
    );
  end

  i2c_bus_events u_ev (
    .scl(syn[0]), .scl_p(prv[0]), .sda(syn[1]), .sda_p(prv[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  i2c_tgt_fsm #(
    .DW(DATA_W), .PW(PTR_W), .AW(STRAP_W), .PREFIX(PREFIX)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda(syn[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c),
    .strap(strap), .rd_data(rd_data), .sda_oe(sda_oe), .ptr(reg_idx),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb)
  );
endmodule

// File: rtl/i2c_regptr_chk.sv
module i2c_regptr_chk #(
  parameter int PTR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic [PTR_W-1:0] reg_idx
);
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb)); // R11
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R11
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb); // R8
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i); // R10
  AST_WR_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $stable(reg_idx)); // R6
  AST_WR_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !scl_i); // R6
endmodule

bind i2c_regptr_target i2c_regptr_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .wr_stb(wr_stb), .rd_stb(rd_stb), .reg_idx(reg_idx)
);

// File: tb/tb_i2c_regptr_target.sv
module tb_i2c_regptr_target;
  localparam int CLK_PERIOD = 10;
  localparam int QC = 16;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] A_WR = {4'b0100, STRAP, 1'b0};
  localparam logic [7:0] A_RD = {4'b0100, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, wr_stb, rd_stb;
  logic [1:0] reg_idx;
  logic [7:0] wr_data, rd_data, in0;
  logic [7:0] core [4];
  wire sda_bus = m_sda & ~sda_oe;
  int checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0;
  int exp_ptr = 0;
  bit quiet = 1'b0;
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regptr_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap(STRAP), .reg_idx(reg_idx), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_data(rd_data)
  );

  assign rd_data = (reg_idx == 2'd0) ? in0 : core[reg_idx];

  always @(posedge clk) begin
    if (wr_stb) begin core[reg_idx] <= wr_data; wr_cnt <= wr_cnt + 1; end
    if (rd_stb) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock model comparison, sampled 3 ns after the edge
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      if (prev_scl && m_scl && (sda_oe != prev_oe)) chk("R10 oe moved with SCL high", 1, 0);
      if (quiet) begin
        chk("R7 idle pointer", int'(reg_idx), exp_ptr);
        chk("R9 idle release", int'(sda_oe), 0);
      end
      prev_scl = m_scl;
      prev_oe  = sda_oe;
    end
  end

  task automatic q(); repeat (QC) @(negedge clk); endtask
  task automatic bstart(); m_sda = 1; q(); m_scl = 1; q(); m_sda = 0; q(); m_scl = 0; q(); endtask
  task automatic bstop(); m_sda = 0; q(); m_scl = 1; q(); m_sda = 1; q(); endtask
  task automatic wbit(input logic b); m_sda = b; q(); m_scl = 1; q(); q(); m_scl = 0; q(); endtask
  task automatic rbit(output logic b); m_sda = 1; q(); m_scl = 1; q(); b = sda_bus; q(); m_scl = 0; q(); endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(s);
    ack = ~s;
  endtask

  task automatic rbyte(output logic [7:0] v, input logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin rbit(s); v[i] = s; end
    wbit(~mack);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] v;
    int w0, r0;
    core[0] = 8'h00; core[1] = 8'h00; core[2] = 8'h00; core[3] = 8'h00;
    in0 = 8'h01;
    repeat (5) @(negedge clk);
    chk("R1 reset oe", int'(sda_oe), 0);
    chk("R1 reset wr", int'(wr_stb), 0);
    chk("R1 reset idx", int'(reg_idx), 0);
    rst_n = 1'b1;
    q();
    quiet = 1;

    // R3 R5 R6 single write
    quiet = 0;
    bstart(); wbyte(A_WR, ack); chk("R3 address ack", int'(ack), 1);
    wbyte(8'h01, ack); chk("R5 command ack", int'(ack), 1);
    wbyte(8'hA5, ack); chk("R6 data ack", int'(ack), 1);
    bstop(); exp_ptr = 1; q();
    chk("R6 write landed", int'(core[1]), 8'hA5);
    chk("R6 one strobe", wr_cnt, 1);
    quiet = 1; q();

    // R6 burst to one register
    quiet = 0;
    bstart(); wbyte(A_WR, ack); wbyte(8'h03, ack);
    wbyte(8'h11, ack); wbyte(8'h22, ack);
    bstop(); exp_ptr = 3; q();
    chk("R6 burst last byte", int'(core[3]), 8'h22);
    chk("R6 burst strobes", wr_cnt, 3);
    quiet = 1; q();

    // R8 R9 repeated-start read of reg 1
    quiet = 0;
    r0 = rd_cnt;
    bstart(); wbyte(A_WR, ack); wbyte(8'h01, ack); exp_ptr = 1;
    bstart(); wbyte(A_RD, ack); chk("R3 read address ack", int'(ack), 1);
    rbyte(v, 1'b1); chk("R8 first byte", int'(v), 8'hA5);
    rbyte(v, 1'b0); chk("R8 acked repeat", int'(v), 8'hA5);
    q(); q();
    chk("R9 released after nack", int'(sda_oe), 0);
    bstop(); q();
    chk("R8 read strobes", rd_cnt - r0, 2);
    quiet = 1; q();

    // R7 bare read keeps pointer
    quiet = 0;
    bstart(); wbyte(A_RD, ack); rbyte(v, 1'b0); bstop();
    chk("R7 sticky pointer read", int'(v), 8'hA5);
    quiet = 1; q();

    // R5 only low bits index
    quiet = 0;
    bstart(); wbyte(A_WR, ack); wbyte(8'hFE, ack); wbyte(8'h3C, ack); bstop();
    exp_ptr = 2; q();
    chk("R5 low bits select reg2", int'(core[2]), 8'h3C);
    quiet = 1; q();

    // R8 MSB first through reg 0
    quiet = 0;
    bstart(); wbyte(A_WR, ack); wbyte(8'h00, ack); exp_ptr = 0;
    bstart(); wbyte(A_RD, ack); rbyte(v, 1'b0); bstop();
    chk("R8 msb first 01", int'(v), 8'h01);
    in0 = 8'hC6;
    bstart(); wbyte(A_RD, ack); rbyte(v, 1'b0); bstop();
    chk("R8 msb first C6", int'(v), 8'hC6);
    quiet = 1; q();

    // R4 wrong strap and wrong prefix
    quiet = 0;
    w0 = wr_cnt;
    bstart(); wbyte({4'b0100, 3'b100, 1'b0}, ack); chk("R4 strap mismatch nack", int'(ack), 0);
    wbyte(8'h01, ack); chk("R4 later byte ignored", int'(ack), 0);
    bstop();
    bstart(); wbyte({4'b0101, STRAP, 1'b0}, ack); chk("R4 prefix mismatch nack", int'(ack), 0);
    bstop(); q();
    chk("R4 no strobe", wr_cnt - w0, 0);
    quiet = 1; q();

    // R2 START mid-byte aborts
    quiet = 0;
    w0 = wr_cnt;
    bstart(); wbyte(A_WR, ack); wbyte(8'h01, ack); exp_ptr = 1;
    wbit(1); wbit(1); wbit(0); wbit(0);
    bstart(); wbyte(A_WR, ack); chk("R2 address after abort", int'(ack), 1);
    wbyte(8'h03, ack); wbyte(8'h77, ack); bstop(); exp_ptr = 3; q();
    chk("R2 abort wrote nothing extra", wr_cnt - w0, 1);
    chk("R2 reg1 untouched", int'(core[1]), 8'hA5);
    chk("R2 new write landed", int'(core[3]), 8'h77);
    quiet = 1; q();

    finish_run();
  end
endmodule